// File: doc/BRIEF.md
# Memory Operation Ordering Scoreboard

This block keeps track of memory operations that have already received a translated physical address and are waiting to go to a load or store unit. It has one slot for each entry of the instruction window, and the window entry number selects the slot. When the address stage writes a slot, the block compares the new operation with every live slot. It records which older operations must finish first, and it also marks which younger operations already present now have to wait for the new one. Each cycle the block releases up to a fixed number of operations that are free to go. A released slot empties on the next clock edge.

Operations have no fixed order of their own. The only ordering comes from the recorded pairwise blocking relations and from the circular age order set by the window head pointer. A younger load that touches bytes no older store touches can therefore leave before a stalled older store. A slot written in the current cycle takes part in that cycle's selection, so an operation can reach a load/store unit one cycle after its address is computed. A flush mask removes squashed operations and their blocking effect in the same cycle.

Top module: `mem_order_sb`

## Requirements
- R1: After reset every slot is empty and no grant is asserted, whatever the other inputs are.
- R2: A slot written this cycle with no blocker, no unresolved older entry and no missing data is granted in that same cycle. A granted slot is empty from the next cycle onward.
- R3: Two operations conflict when at least one of them is a store (kind 1), their word addresses are equal, and their 8-bit byte masks share at least one set bit. The younger of the two is not granted until the older has been granted. This applies both to a load behind a store and to a store behind a store.
- R4: Operations that use different word addresses, or the same word with disjoint byte masks, never block each other. A younger load therefore passes an older store that is stalled for data.
- R5: A fence (kind 2) or atomic (kind 3) conflicts with every other operation regardless of address. It waits for all older operations, and all younger operations wait for it.
- R6: A store (kind 1) or atomic (kind 3) is not granted while its data_ready_i bit is 0. A load (kind 0) or fence (kind 2) needs no data.
- R7: A slot is not granted while unresolved_i has a bit set for any window entry older than that slot. Bits for younger entries do not hold it.
- R8: Age is (index − head_i) mod NSLOT, and a smaller value means older. Conflict direction follows this age order even when the younger operation was written first or the indices wrap.
- R9: At most NGRANT slots are granted per cycle. Ready loads are chosen first, then the other kinds. Within each class the oldest is chosen first. Grant ports are filled from port 0 upward.
- R10: A slot whose flush_i bit is set is never granted. It is empty from the next cycle, and in that same cycle it stops blocking other slots. A write to a slot that is flushed in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_i | input | IDXW | Index of the oldest window entry |
| unresolved_i | input | NSLOT | Window entries holding memory operations that have no address yet |
| wr_valid_i | input | 1 | The address stage writes a slot this cycle |
| wr_idx_i | input | IDXW | Slot (window entry) being written |
| wr_addr_i | input | WA_W | Physical word address of the written operation |
| wr_mask_i | input | MW | Byte mask within the word |
| wr_kind_i | input | 2 | 0 load, 1 store, 2 fence, 3 atomic |
| data_ready_i | input | NSLOT | Store data available, one bit per slot |
| flush_i | input | NSLOT | Slots to squash this cycle |
| grant_valid_o | output | NGRANT | Grant port carries a released slot |
| grant_idx_o | output | NGRANT×IDXW | Released slot index per port |
| grant_load_o | output | NGRANT | Released operation is a load |

## Verification
Stimulus comes in several shapes, and each one separates a different faulty ordering. Overlapping and disjoint byte masks within one word show whether the block compares exact bytes or only word addresses. Fences and atomics placed between a stalled store and an unrelated load show whether barrier ordering is kept in both directions. A wrapped head pointer, with the younger operation written first, shows whether age is taken modulo the window or from the raw index. A burst of seven ready operations of mixed kinds shows whether loads take precedence, whether the oldest goes first within each class, and whether the port cap holds. A flush of a blocking store shows whether the blocker is dropped in the same cycle and whether a write into a squashed slot is lost.

// File: rtl/mtsb_pkg.sv
package mtsb_pkg;

   typedef enum logic [1:0] {
      OP_LOAD   = 2'd0,
      OP_STORE  = 2'd1,
      OP_FENCE  = 2'd2,
      OP_ATOMIC = 2'd3
   } op_kind_e;

   // kinds that write memory and therefore wait for their data operand
   function automatic logic kind_needs_data(input logic [1:0] k);
      return (k == OP_STORE) || (k == OP_ATOMIC);
   endfunction

   // kinds that order against every other operation
   function automatic logic kind_is_barrier(input logic [1:0] k);
      return (k == OP_FENCE) || (k == OP_ATOMIC);
   endfunction

   function automatic logic kind_writes(input logic [1:0] k);
      return (k == OP_STORE);
   endfunction

endpackage

// File: rtl/mtsb_hazard_gen.sv
module mtsb_hazard_gen
   import mtsb_pkg::*;
#(
   parameter int NSLOT = 16,
   parameter int WA_W  = 53,
   parameter int MW    = 8,
   localparam int IDXW = $clog2(NSLOT)
) (
   input  logic [IDXW-1:0]             head_i,
   input  logic [NSLOT-1:0]            live_i,
   input  logic [NSLOT-1:0][WA_W-1:0]  addr_i,
   input  logic [NSLOT-1:0][MW-1:0]    mask_i,
   input  logic [NSLOT-1:0][1:0]       kind_i,
   input  logic [IDXW-1:0]             wr_idx_i,
   input  logic [WA_W-1:0]             wr_addr_i,
   input  logic [MW-1:0]               wr_mask_i,
   input  logic [1:0]                  wr_kind_i,
   output logic [NSLOT-1:0]            blocked_by_o,
   output logic [NSLOT-1:0]            blocks_o
);

   logic [IDXW-1:0] wr_age;
   assign wr_age = wr_idx_i - head_i;

   for (genvar j = 0; j < NSLOT; j++) begin : g_pair
      logic [IDXW-1:0] age_j;
      logic            overlap;
      logic            ordered;
      logic            other;
      assign age_j   = IDXW'(j) - head_i;
      assign overlap = (addr_i[j] == wr_addr_i) && (|(mask_i[j] & wr_mask_i));
      assign ordered = kind_is_barrier(kind_i[j]) || kind_is_barrier(wr_kind_i) ||
                       ((kind_writes(kind_i[j]) || kind_writes(wr_kind_i)) && overlap);
      assign other   = live_i[j] && (wr_idx_i != IDXW'(j)) && ordered;
      assign blocked_by_o[j] = other && (age_j < wr_age);
      assign blocks_o[j]     = other && (age_j > wr_age);
   end

endmodule

// File: rtl/mtsb_pick.sv
module mtsb_pick #(
   parameter int NSLOT  = 16,
   parameter int NGRANT = 4,
   localparam int IDXW  = $clog2(NSLOT)
) (
   input  logic [IDXW-1:0]              head_i,
   input  logic [NSLOT-1:0]             ready_i,
   input  logic [NSLOT-1:0]             load_i,
   output logic [NGRANT-1:0]            gnt_v_o,
   output logic [NGRANT-1:0][IDXW-1:0]  gnt_idx_o,
   output logic [NSLOT-1:0]             gnt_oh_o
);

   // pass 0 takes loads, pass 1 the rest; oldest first inside a pass
   always_comb begin
      int taken;
      taken     = 0;
      gnt_v_o   = '0;
      gnt_idx_o = '0;
      gnt_oh_o  = '0;
      for (int pass = 0; pass < 2; pass++) begin
         for (int k = 0; k < NSLOT; k++) begin
            logic [IDXW-1:0] p;
            p = head_i + IDXW'(k);
            if (taken < NGRANT && ready_i[p] && (load_i[p] == (pass == 0))) begin
               for (int g = 0; g < NGRANT; g++) begin
                  if (g == taken) begin
                     gnt_v_o[g]   = 1'b1;
                     gnt_idx_o[g] = p;
                  end
               end
               gnt_oh_o[p] = 1'b1;
               taken = taken + 1;
            end
         end
      end
   end

endmodule

// File: rtl/mem_order_sb.sv
module mem_order_sb
   import mtsb_pkg::*;
#(
   parameter int NSLOT  = 16,
   parameter int NGRANT = 4,
   parameter int WA_W   = 53,
   parameter int MW     = 8,
   localparam int IDXW  = $clog2(NSLOT)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [IDXW-1:0]             head_i,
   input  logic [NSLOT-1:0]            unresolved_i,
   input  logic                        wr_valid_i,
   input  logic [IDXW-1:0]             wr_idx_i,
   input  logic [WA_W-1:0]             wr_addr_i,
   input  logic [MW-1:0]               wr_mask_i,
   input  logic [1:0]                  wr_kind_i,
   input  logic [NSLOT-1:0]            data_ready_i,
   input  logic [NSLOT-1:0]            flush_i,
   output logic [NGRANT-1:0]           grant_valid_o,
   output logic [NGRANT-1:0][IDXW-1:0] grant_idx_o,
   output logic [NGRANT-1:0]           grant_load_o
);

   if (NSLOT != (1 << IDXW)) begin : g_bad_slots
      $error("mem_order_sb: NSLOT must be a power of two");
   end
   if (NGRANT < 1 || NGRANT > NSLOT) begin : g_bad_grants
      $error("mem_order_sb: NGRANT must lie in 1..NSLOT");
   end

   logic [NSLOT-1:0]              valid_q;
   logic [NSLOT-1:0][WA_W-1:0]    addr_q;
   logic [NSLOT-1:0][MW-1:0]      mask_q;
   logic [NSLOT-1:0][1:0]         kind_q;
   logic [NSLOT-1:0][NSLOT-1:0]   haz_q;

   logic [NSLOT-1:0]              wr_take;
   logic [NSLOT-1:0]              blocked_by;
   logic [NSLOT-1:0]              blocks;
   logic [NSLOT-1:0][NSLOT-1:0]   haz_eff;
   logic [NSLOT-1:0][NSLOT-1:0]   older_m;
   logic [NSLOT-1:0][IDXW-1:0]    age;
   logic [NSLOT-1:0][1:0]         kind_eff;
   logic [NSLOT-1:0]              live_eff;
   logic [NSLOT-1:0]              ready;
   logic [NSLOT-1:0]              is_load;
   logic [NSLOT-1:0]              gnt_oh;
   logic [NSLOT-1:0]              leave;

   // a write into a slot squashed in the same cycle is dropped
   assign wr_take = (wr_valid_i ? (NSLOT'(1) << wr_idx_i) : '0) & ~flush_i;

   mtsb_hazard_gen #(.NSLOT(NSLOT), .WA_W(WA_W), .MW(MW)) u_haz (
      .head_i      (head_i),
      .live_i      (valid_q & ~flush_i),
      .addr_i      (addr_q),
      .mask_i      (mask_q),
      .kind_i      (kind_q),
      .wr_idx_i    (wr_idx_i),
      .wr_addr_i   (wr_addr_i),
      .wr_mask_i   (wr_mask_i),
      .wr_kind_i   (wr_kind_i),
      .blocked_by_o(blocked_by),
      .blocks_o    (blocks)
   );

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      assign age[i] = IDXW'(i) - head_i;
      for (genvar j = 0; j < NSLOT; j++) begin : g_age
         assign older_m[i][j] = age[j] < age[i];
      end
      // bypass: the slot written now is judged by its fresh hazard row
      assign haz_eff[i]  = (wr_take[i] ? blocked_by
                                       : (haz_q[i] | (blocks[i] ? wr_take : '0))) & ~flush_i;
      assign kind_eff[i] = wr_take[i] ? wr_kind_i : kind_q[i];
      assign live_eff[i] = (valid_q[i] | wr_take[i]) & ~flush_i[i];
      assign is_load[i]  = (kind_eff[i] == OP_LOAD);
      assign ready[i]    = live_eff[i] && (haz_eff[i] == '0) &&
                           !(|(unresolved_i & older_m[i])) &&
                           (!kind_needs_data(kind_eff[i]) || data_ready_i[i]);
   end

   mtsb_pick #(.NSLOT(NSLOT), .NGRANT(NGRANT)) u_pick (
      .head_i   (head_i),
      .ready_i  (ready),
      .load_i   (is_load),
      .gnt_v_o  (grant_valid_o),
      .gnt_idx_o(grant_idx_o),
      .gnt_oh_o (gnt_oh)
   );

   for (genvar g = 0; g < NGRANT; g++) begin : g_port
      assign grant_load_o[g] = grant_valid_o[g] & is_load[grant_idx_o[g]];
   end

   assign leave = gnt_oh | flush_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         haz_q   <= '0;
      end else begin
         for (int i = 0; i < NSLOT; i++) begin
            if (leave[i]) begin
               valid_q[i] <= 1'b0;
               haz_q[i]   <= '0;
            end else begin
               if (wr_take[i]) valid_q[i] <= 1'b1;
               haz_q[i] <= haz_eff[i] & ~gnt_oh;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < NSLOT; i++) begin
         if (wr_take[i]) begin
            addr_q[i] <= wr_addr_i;
            mask_q[i] <= wr_mask_i;
            kind_q[i] <= wr_kind_i;
         end
      end
   end

   // R2: the address stage only writes empty slots
   a_r2_write_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_i |-> !valid_q[wr_idx_i]);

   // R9: the picker never exceeds its port count
   a_r9_grant_cap: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gnt_oh) <= NGRANT);

   for (genvar i = 0; i < NSLOT; i++) begin : g_chk
      // R2: a released slot is empty afterwards
      a_r2_granted_leaves: assert property (@(posedge clk) disable iff (!rst_n)
         gnt_oh[i] |=> !valid_q[i]);
      // R10: a squashed slot is empty afterwards and is never released
      a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
         flush_i[i] |=> !valid_q[i]);
      a_r10_flush_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
         flush_i[i] |-> !gnt_oh[i]);
      // R3: stored blockers always name live slots other than itself
      a_r3_no_stale_bits: assert property (@(posedge clk) disable iff (!rst_n)
         ((haz_q[i] & ~valid_q) == '0) && !haz_q[i][i]);
      // R6: data-carrying kinds are never released without data
      a_r6_data_present: assert property (@(posedge clk) disable iff (!rst_n)
         (gnt_oh[i] && kind_needs_data(kind_eff[i])) |-> data_ready_i[i]);
   end

endmodule

// File: tb/tb_mem_order_sb.sv
module tb_mem_order_sb;

   localparam int CLK_PERIOD = 10;
   localparam int NS = 16;
   localparam int NG = 4;
   localparam logic [1:0] K_LD = 2'd0, K_ST = 2'd1, K_FN = 2'd2, K_AT = 2'd3;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [3:0]        head;
   logic [NS-1:0]     unres;
   logic              wr_valid;
   logic [3:0]        wr_idx;
   logic [52:0]       wr_addr;
   logic [7:0]        wr_mask;
   logic [1:0]        wr_kind;
   logic [NS-1:0]     dready;
   logic [NS-1:0]     flush;
   logic [NG-1:0]     gv;
   logic [NG-1:0][3:0] gi;
   logic [NG-1:0]     gl;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mem_order_sb dut (
      .clk(clk), .rst_n(rst_n), .head_i(head), .unresolved_i(unres),
      .wr_valid_i(wr_valid), .wr_idx_i(wr_idx), .wr_addr_i(wr_addr),
      .wr_mask_i(wr_mask), .wr_kind_i(wr_kind), .data_ready_i(dready),
      .flush_i(flush), .grant_valid_o(gv), .grant_idx_o(gi), .grant_load_o(gl)
   );

   localparam logic [52:0] A = 53'h1000, B = 53'h2000, C = 53'h3000;

   task automatic do_reset();
      rst_n = 1'b0; head = '0; unres = '0; wr_valid = 1'b0; wr_idx = '0;
      wr_addr = '0; wr_mask = '0; wr_kind = K_LD; dready = '0; flush = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // advance to the next negedge and clear one-shot inputs
   task automatic next();
      @(negedge clk);
      wr_valid = 1'b0;
      flush    = '0;
   endtask

   task automatic wr(input int idx, input logic [1:0] k, input logic [52:0] a,
                     input logic [7:0] m);
      wr_valid = 1'b1; wr_idx = 4'(idx); wr_kind = k; wr_addr = a; wr_mask = m;
   endtask

   task automatic expect_gnt(input logic [NS-1:0] exp, input string tag);
      logic [NS-1:0] got;
      #1;
      got = '0;
      for (int g = 0; g < NG; g++) if (gv[g]) got[gi[g]] = 1'b1;
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: grant mask actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic expect_port(input int g, input logic v, input int idx,
                              input logic ld, input string tag);
      n_chk++;
      if (gv[g] !== v || (v && (gi[g] !== 4'(idx) || gl[g] !== ld))) begin
         n_bad++;
         $display("FAIL %s: port%0d actual v=%b idx=%0d ld=%b expected v=%b idx=%0d ld=%b",
                  tag, g, gv[g], gi[g], gl[g], v, idx, ld);
      end
   endtask

   task automatic t_reset();
      do_reset();
      dready = '1;
      next(); expect_gnt('0, "R1 idle after reset");
      next(); expect_gnt('0, "R1 second idle cycle");
   endtask

   task automatic t_bypass();
      do_reset();
      next(); wr(3, K_LD, A, 8'hFF); expect_gnt(16'h0008, "R2 same-cycle grant");
      expect_port(0, 1'b1, 3, 1'b1, "R2 port0 load");
      next(); expect_gnt('0, "R2 slot gone after grant");
   endtask

   task automatic t_overlap();
      do_reset();
      next(); wr(1, K_ST, A, 8'h0F); expect_gnt('0, "R6 store waits data");
      next(); wr(2, K_LD, A, 8'h08); expect_gnt('0, "R3 load behind store");
      next(); expect_gnt('0, "R3 still blocked");
      next(); dready[1] = 1'b1; expect_gnt(16'h0002, "R3 store leaves alone");
      next(); expect_gnt(16'h0004, "R3 load after store");
   endtask

   task automatic t_disjoint();
      do_reset();
      next(); wr(1, K_ST, A, 8'h0F); expect_gnt('0, "R4 stalled store");
      next(); wr(2, K_LD, A, 8'hF0); expect_gnt(16'h0004, "R4 disjoint bytes pass");
      next(); wr(3, K_LD, B, 8'h0F); expect_gnt(16'h0008, "R4 other word passes");
      next(); dready[4] = 1'b1; wr(4, K_ST, A, 8'h01);
      expect_gnt('0, "R3 store behind store");
   endtask

   task automatic t_fence();
      do_reset();
      next(); wr(0, K_ST, A, 8'hFF); expect_gnt('0, "R5 older store stalled");
      next(); wr(1, K_FN, C, 8'h00); expect_gnt('0, "R5 fence waits older");
      next(); wr(2, K_LD, B, 8'h01); expect_gnt('0, "R5 load waits fence");
      next(); dready[0] = 1'b1; expect_gnt(16'h0001, "R5 store first");
      next(); expect_gnt(16'h0002, "R5 fence second");
      next(); expect_gnt(16'h0004, "R5 load third");
   endtask

   task automatic t_data();
      do_reset();
      next(); wr(5, K_ST, A, 8'h01); expect_gnt('0, "R6 store no data");
      next(); expect_gnt('0, "R6 store still no data");
      next(); dready[5] = 1'b1; expect_gnt(16'h0020, "R6 store with data");
      next(); wr(6, K_AT, B, 8'hFF); expect_gnt('0, "R6 atomic no data");
      next(); dready[6] = 1'b1; expect_gnt(16'h0040, "R6 atomic with data");
   endtask

   task automatic t_unresolved();
      do_reset();
      unres[0] = 1'b1;
      next(); wr(4, K_LD, A, 8'hFF); expect_gnt('0, "R7 older unresolved holds");
      next(); expect_gnt('0, "R7 still held");
      next(); unres = '0; expect_gnt(16'h0010, "R7 released");
      next(); unres[9] = 1'b1; wr(6, K_LD, B, 8'hFF);
      expect_gnt(16'h0040, "R7 younger unresolved ignored");
   endtask

   task automatic t_wrap();
      do_reset();
      head = 4'd14; unres[15] = 1'b1;
      next(); wr(2, K_LD, A, 8'h01); expect_gnt('0, "R8 load held by entry 15");
      next(); unres = '0; wr(15, K_ST, A, 8'hFF);
      expect_gnt('0, "R8 older store written later blocks");
      next(); expect_gnt('0, "R8 load stays blocked");
      next(); dready[15] = 1'b1; expect_gnt(16'h8000, "R8 wrapped store first");
      next(); expect_gnt(16'h0004, "R8 load after wrap");
   endtask

   task automatic t_priority();
      do_reset();
      head = 4'd8; unres[8] = 1'b1;
      for (int s = 9; s <= 11; s++) begin
         next(); wr(s, K_ST, 53'(A + s), 8'hFF); expect_gnt('0, "R9 fill store");
      end
      for (int s = 12; s <= 15; s++) begin
         next(); wr(s, K_LD, 53'(B + s), 8'hFF); expect_gnt('0, "R9 fill load");
      end
      next(); unres = '0; dready = '1; #1;
      expect_port(0, 1'b1, 12, 1'b1, "R9 loads first p0");
      expect_port(1, 1'b1, 13, 1'b1, "R9 loads first p1");
      expect_port(2, 1'b1, 14, 1'b1, "R9 loads first p2");
      expect_port(3, 1'b1, 15, 1'b1, "R9 loads first p3");
      next(); #1;
      expect_port(0, 1'b1, 9, 1'b0, "R9 oldest store p0");
      expect_port(1, 1'b1, 10, 1'b0, "R9 store p1");
      expect_port(2, 1'b1, 11, 1'b0, "R9 store p2");
      expect_port(3, 1'b0, 0, 1'b0, "R9 port3 idle");
      next(); expect_gnt('0, "R9 drained");
   endtask

   task automatic t_flush();
      do_reset();
      next(); wr(1, K_ST, A, 8'hFF); expect_gnt('0, "R10 stalled store");
      next(); wr(2, K_LD, A, 8'h10); expect_gnt('0, "R10 load blocked");
      next(); flush[1] = 1'b1; expect_gnt(16'h0004, "R10 blocker gone same cycle");
      next(); dready[1] = 1'b1; expect_gnt('0, "R10 flushed store never granted");
      next(); flush[5] = 1'b1; wr(5, K_LD, C, 8'h01); expect_gnt('0, "R10 flushed write");
      next(); expect_gnt('0, "R10 dropped write left nothing");
      next(); wr(5, K_LD, C, 8'h01); expect_gnt(16'h0020, "R10 slot free again");
   endtask

   initial begin
      t_reset();
      t_bypass();
      t_overlap();
      t_disjoint();
      t_fence();
      t_data();
      t_unresolved();
      t_wrap();
      t_priority();
      t_flush();
      next();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule